// File: doc/BRIEF.md
# Pre-decoded Shift-and-Compare String Matcher

This block scans a payload byte stream, one byte per clock, for a fixed set of literal strings chosen at elaboration. Each accepted byte is turned once into one-hot character lines, and each line feeds its own one-bit delay line. A pattern group holds one line for each distinct character its patterns use. A string matcher is then only an AND of taps from those delay lines, with each tap's depth set by the character's position in the string. Many matchers share the same decode and delay hardware.

One match bit per pattern leaves a register every cycle. A start-of-stream strobe drops all history, so bytes of two unrelated streams never combine into a match. The strings, their lengths and their group numbers are parameters. Each string is stored left-justified in a field of `MAX_LEN` bytes, and pattern 0 occupies the least significant field.

Top module: `prefix_char_matcher`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `match_o` is all zero. No bytes accepted before reset take part in a later match.
- R2: Pattern p of length L is laid out as character position i (0 = first byte) at bits `[p*MAX_LEN*8 + (MAX_LEN-1-i)*8 +: 8]` of `PAT_BYTES`. Its length is `PAT_LEN[p*8 +: 8]` and its group is `PAT_GRP[p*8 +: 8]`.
- R3: `match_o[p]` is high in exactly the cycle after the L-th of L consecutively accepted bytes that equal pattern p, position by position.
- R4: Several patterns can match in the same cycle. A pattern that overlaps itself matches on every accepted byte that completes it.
- R5: A cycle with `in_valid` low changes no history and gives all-zero `match_o` on the next cycle. Idle gaps between accepted bytes do not break a match.
- R6: With `in_valid` high, `stream_start` marks the byte as the first of a new stream. Only length-1 patterns can match on it, and later matches see no earlier byte. With `in_valid` low, `stream_start` clears all history.
- R7: An accepted byte that differs from the expected character at its position breaks the match, whether or not any pattern uses that byte.
- R8: The same character used in two groups is decoded independently per group. Matches in one group never depend on the other group's patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_byte` is accepted this cycle |
| in_byte | input | 8 | Payload byte |
| stream_start | input | 1 | Start of a new stream; clears history |
| match_o | output | NUM_PAT | Registered match bit for each pattern |

## Verification
A stuck or misshifted bit in a character delay line shows up on `match_o` at the end of the first string that uses that character at that depth. The error appears at most `MAX_LEN` accepted bytes after the bad bit entered the line. A clear that fails on `stream_start` surfaces as a false match on the first bytes of the next stream. A shift taken on an idle cycle makes a gapped string miss one cycle after its last byte. The directed streams are built so that each of these faults changes some match bit.

// File: rtl/prefix_char_matcher.sv
module prefix_char_matcher #(
  parameter int NUM_PAT = 5,
  parameter int MAX_LEN = 6,
  parameter int NUM_GRP = 2,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PAT_BYTES =
    {{"ii", 32'h0}, {"x", 40'h0}, {"cgi", 24'h0}, {"tack", 16'h0}, "attack"},
  parameter logic [NUM_PAT*8-1:0] PAT_LEN = {8'd2, 8'd1, 8'd3, 8'd4, 8'd6},
  parameter logic [NUM_PAT*8-1:0] PAT_GRP = {8'd1, 8'd1, 8'd1, 8'd0, 8'd0}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  input  logic               stream_start,
  output logic [NUM_PAT-1:0] match_o
);
  localparam int NCH   = 256;
  localparam int NLINE = NUM_GRP * NCH;

  function automatic int plen(int p);
    return int'(PAT_LEN[p*8 +: 8]);
  endfunction

  function automatic int pgrp(int p);
    return int'(PAT_GRP[p*8 +: 8]);
  endfunction

  function automatic int pchar(int p, int i);
    return int'(PAT_BYTES[p*MAX_LEN*8 + (MAX_LEN-1-i)*8 +: 8]);
  endfunction

  function automatic bit used(int g, int c);
    for (int p = 0; p < NUM_PAT; p++)
      for (int i = 0; i < MAX_LEN; i++)
        if (pgrp(p) == g && i < plen(p) && pchar(p, i) == c) return 1'b1;
    return 1'b0;
  endfunction

  // line[k] = character seen k accepted bytes ago (k = 0 is the current byte)
  logic [MAX_LEN-1:0] line [NLINE];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar c = 0; c < NCH; c++) begin : g_chr
      if (used(g, c)) begin : g_live
        logic [MAX_LEN-2:0] hist;
        assign line[g*NCH+c][0] = in_valid && (in_byte == 8'(c));
        assign line[g*NCH+c][MAX_LEN-1:1] = stream_start ? '0 : hist;
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)                          hist <= '0;
          else if (in_valid)                   hist <= line[g*NCH+c][MAX_LEN-2:0];
          else if (stream_start)               hist <= '0;
      end else begin : g_dead
        assign line[g*NCH+c] = '0;
      end
    end
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    logic [MAX_LEN-1:0] hit;
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_pos
      if (i < plen(p)) begin : g_tap
        assign hit[i] = line[pgrp(p)*NCH + pchar(p, i)][plen(p)-1-i];
      end else begin : g_pad
        assign hit[i] = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) match_o[p] <= 1'b0;
      else        match_o[p] <= &hit;
  end
endmodule

// File: rtl/match_checker.sv
module match_checker #(
  parameter int NUM_PAT = 5,
  parameter int MAX_LEN = 6,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PAT_BYTES = '0,
  parameter logic [NUM_PAT*8-1:0] PAT_LEN = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [7:0]         in_byte,
  input logic               stream_start,
  input logic [NUM_PAT-1:0] match_o
);
  function automatic logic [7:0] pc(int p, int i);
    return PAT_BYTES[p*MAX_LEN*8 + (MAX_LEN-1-i)*8 +: 8];
  endfunction

  function automatic logic [NUM_PAT-1:0] long_mask();
    logic [NUM_PAT-1:0] m = '0;
    for (int p = 0; p < NUM_PAT; p++) m[p] = (PAT_LEN[p*8 +: 8] > 8'd1);
    return m;
  endfunction

  localparam logic [NUM_PAT-1:0] LONG = long_mask();

  logic       prev_vld;
  logic [7:0] prev_byte;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_vld  <= 1'b0;
      prev_byte <= '0;
    end else if (in_valid) begin
      prev_vld  <= 1'b1;
      prev_byte <= in_byte;
    end else if (stream_start) begin
      prev_vld  <= 1'b0;
    end

  a_r5_idle_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> match_o == '0);

  a_r6_start_short_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stream_start) |=> (match_o & LONG) == '0);

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_p
    localparam int L = int'(PAT_LEN[p*8 +: 8]);
    a_r3_last_char: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_byte == pc(p, L-1)) |=> !match_o[p]);
    if (L > 1) begin : g_two
      a_r7_prev_char: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !stream_start && prev_vld && prev_byte == pc(p, L-2))
          |=> !match_o[p]);
    end
  end
endmodule

bind prefix_char_matcher match_checker #(
  .NUM_PAT(NUM_PAT), .MAX_LEN(MAX_LEN), .PAT_BYTES(PAT_BYTES), .PAT_LEN(PAT_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .stream_start(stream_start), .match_o(match_o)
);

// File: tb/prefix_char_matcher_tb_top.sv
module prefix_char_matcher_tb_top;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h0;
  logic          stream_start = 1'b0;
  logic [NP-1:0] match_o;

  int checks = 0;
  int fails  = 0;
  byte hist [$];
  string pats [NP] = '{"attack", "tack", "cgi", "x", "ii"};

  always #10 clk = ~clk;

  prefix_char_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .stream_start(stream_start), .match_o(match_o)
  );

  function automatic logic [NP-1:0] model(input logic v);
    logic [NP-1:0] e = '0;
    if (!v) return e;
    for (int p = 0; p < NP; p++) begin
      int L = pats[p].len();
      if (hist.size() >= L) begin
        e[p] = 1'b1;
        for (int i = 0; i < L; i++)
          if (hist[hist.size()-L+i] != pats[p][i]) e[p] = 1'b0;
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] exp);
    checks++;
    if (match_o !== exp) begin
      fails++;
      $display("FAIL %s match actual=%b expected=%b", tag, match_o, exp);
    end
  endtask

  task automatic step(input byte b, input logic v, input logic s, input string tag);
    logic [NP-1:0] exp;
    in_byte = b; in_valid = v; stream_start = s;
    if (s) hist.delete();
    if (v) hist.push_back(b);
    exp = model(v);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic send(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) step(s[i], 1'b1, 1'b0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(8'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; stream_start = 1'b0;
    hist.delete();
    @(negedge clk);
    check("R1 during reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after reset", '0);
    send("att", "R1");
    do_reset();
    send("ack", "R1 no pre-reset history");
  endtask

  task automatic t_basic();
    send("zzattackzcgiz", "R3 basic R2 layout");
    send("x", "R3 single byte");
    idle(1, "R3");
  endtask

  task automatic t_overlap();
    send("attackiiii", "R4 overlap");
    send("cgiix", "R4 cross-group R8");
  endtask

  task automatic t_gaps();
    send("a", "R5"); idle(2, "R5 idle");
    send("tt", "R5"); idle(1, "R5 idle");
    send("ac", "R5"); idle(3, "R5 idle");
    send("k", "R5 gapped match");
    idle(1, "R5");
  endtask

  task automatic t_start();
    send("atta", "R6");
    step("c", 1'b1, 1'b1, "R6 start with byte");
    send("k", "R6 no tack across start");
    send("cg", "R6");
    step(8'h0, 1'b0, 1'b1, "R6 start without byte");
    send("i", "R6 cleared history");
    send("i", "R6");
    step("x", 1'b1, 1'b1, "R6 single match on start byte");
    send("tac", "R6");
    step("k", 1'b1, 1'b1, "R6 start breaks tack");
  endtask

  task automatic t_break();
    send("attxck", "R7 unused byte");
    send("atack", "R7");
    send("cgg", "R7 wrong char");
    send("tacattack", "R7 restart");
    send("cxi", "R8 group isolation");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_overlap();
    t_gaps();
    t_start();
    t_break();
    idle(2, "R5 tail");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule